// File: doc/BRIEF.md
# Sequential Booth Multiplier

This block multiplies two signed two's-complement operands of `WIDTH` bits over several clock cycles, using one adder/subtractor of `WIDTH+1` bits. A start request copies the multiplicand into a holding register and the multiplier into the low half of a shifting partial-product register. It also clears the upper half of the partial product and a one-bit history register that sits to the right of the multiplier.

On each of `WIDTH` steps, the sequencer reads the lowest bit of the multiplier register together with the history bit. From that pair it adds the multiplicand, subtracts it, or leaves the partial product alone. It then shifts the whole partial product one place to the right. The upper half is kept one bit wider than the operands, and the shift copies its sign bit, so negative partial products keep their sign. For this reason neither operand needs to be negated first.

When the last step completes, the block raises a one-cycle completion pulse. The `2*WIDTH`-bit product then holds its value until the next accepted start.

Top module: `booth_seq_mult`

## Requirements
- R1: After reset, `busy` is 0, `done` is 0 and `product` is all zeros.
- R2: A `start` sampled high while `busy` is 0 loads the operands, and `busy` reads 1 in the following cycle.
- R3: `done` is high for exactly one cycle. It rises on the `WIDTH`-th clock edge after the edge that accepted `start`, and `busy` is 0 in that same cycle.
- R4: When `done` is high, `product` equals the signed product of `multiplicand` and `multiplier`, both read as two's complement, expressed as a `2*WIDTH`-bit two's-complement value. This holds for every operand pair, including the most negative value times itself.
- R5: A `start` sampled while `busy` is 1 has no effect. The running multiplication finishes on schedule with the product of the operands that were accepted first.
- R6: While `busy` is 0 and `start` is low, `product` does not change, whatever the operand inputs do.
- R7: Each step looks at the pair (current multiplier bit, previous bit), with 0 assumed to the right of bit 0. The pair 01 adds the multiplicand, 10 subtracts it, and 00 and 11 only shift. The shift is arithmetic: it copies the sign bit of the upper half.
- R8: Exactly `WIDTH` add/shift steps occur between an accepted start and the completion pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a new multiplication; honoured only when idle |
| multiplicand | input | WIDTH | Signed multiplicand, sampled on the accepting edge |
| multiplier | input | WIDTH | Signed multiplier, sampled on the accepting edge |
| busy | output | 1 | High while steps are in progress |
| done | output | 1 | One-cycle pulse when the product is ready |
| product | output | 2*WIDTH | Signed product, held until the next accepted start |

## Verification
A wrong Booth decision or a logical shift used in place of an arithmetic one corrupts the product. The error appears at the `done` pulse, and it shows up most clearly for negative operands and for the most negative value times itself. An off-by-one in the step counter moves the `done` pulse by a cycle, so the latency count catches it at the end of that same operation. A start that leaks into a running operation shows as a wrong product for the first operand pair, at the end of that run.

// File: rtl/booth_pkg.sv
package booth_pkg;

  typedef enum logic [1:0] {
    BOOTH_NOP = 2'd0,
    BOOTH_ADD = 2'd1,
    BOOTH_SUB = 2'd2
  } booth_op_e;

  // Pair = {current multiplier bit, previously shifted-out bit}
  function automatic booth_op_e booth_decode(input logic cur, input logic prev);
    case ({cur, prev})
      2'b01:   return BOOTH_ADD;
      2'b10:   return BOOTH_SUB;
      default: return BOOTH_NOP;
    endcase
  endfunction

endpackage

// File: rtl/booth_ctrl.sv
module booth_ctrl #(
  parameter int WIDTH = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic load,
  output logic step,
  output logic done
);
  localparam int CW = (WIDTH > 2) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(WIDTH - 1);

  logic [CW-1:0] cnt_q;
  logic          last_step;

  assign load      = start && !busy;
  assign step      = busy;
  assign last_step = step && (cnt_q == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
      done  <= 1'b0;
    end else begin
      done <= last_step;
      if (load) begin
        busy  <= 1'b1;
        cnt_q <= '0;
      end else if (step) begin
        if (last_step) busy <= 1'b0;
        else           cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

endmodule

// File: rtl/booth_datapath.sv
module booth_datapath
  import booth_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               step,
  input  logic [WIDTH-1:0]   mcand,
  input  logic [WIDTH-1:0]   mplier,
  output logic [2*WIDTH-1:0] product,
  output booth_op_e          op
);
  localparam int AW = WIDTH + 1;

  logic [WIDTH-1:0] m_q;
  logic [AW-1:0]    a_q;
  logic [WIDTH-1:0] q_q;
  logic             qm1_q;
  logic [AW-1:0]    acc_sum;

  // Upper partial product plus or minus the sign-extended multiplicand
  function automatic logic [AW-1:0] booth_acc(input logic [AW-1:0] a,
                                              input logic [WIDTH-1:0] m,
                                              input booth_op_e sel);
    logic [AW-1:0] m_ext;
    m_ext = {m[WIDTH-1], m};
    case (sel)
      BOOTH_ADD: return a + m_ext;
      BOOTH_SUB: return a + ~m_ext + AW'(1);
      default:   return a;
    endcase
  endfunction

  assign op      = booth_decode(q_q[0], qm1_q);
  assign acc_sum = booth_acc(a_q, m_q, op);
  assign product = {a_q[WIDTH-1:0], q_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q   <= '0;
      a_q   <= '0;
      q_q   <= '0;
      qm1_q <= 1'b0;
    end else if (load) begin
      m_q   <= mcand;
      a_q   <= '0;
      q_q   <= mplier;
      qm1_q <= 1'b0;
    end else if (step) begin
      a_q   <= {acc_sum[AW-1], acc_sum[AW-1:1]};
      q_q   <= {acc_sum[0], q_q[WIDTH-1:1]};
      qm1_q <= q_q[0];
    end
  end

  p_load_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (a_q == '0) && !qm1_q && (product[WIDTH-1:0] == $past(mplier)));

  p_hold_mcand_r5: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> $stable(m_q));

  p_nop_shift_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && op == BOOTH_NOP) |=> (a_q == $past({a_q[AW-1], a_q[AW-1:1]})));

  p_history_r7: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (qm1_q == $past(q_q[0])));

endmodule

// File: rtl/booth_seq_mult.sv
module booth_seq_mult
  import booth_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [WIDTH-1:0]   multiplicand,
  input  logic [WIDTH-1:0]   multiplier,
  output logic               busy,
  output logic               done,
  output logic [2*WIDTH-1:0] product
);
  logic      load_w;
  logic      step_w;
  booth_op_e op_w;

  booth_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .busy  (busy),
    .load  (load_w),
    .step  (step_w),
    .done  (done)
  );

  booth_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load_w),
    .step    (step_w),
    .mcand   (multiplicand),
    .mplier  (multiplier),
    .product (product),
    .op      (op_w)
  );

  p_idle_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(product));

  p_op_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    op_w != 2'd3);

endmodule

// File: tb/booth_seq_mult_bench.sv
`timescale 1ns/1ps
module booth_seq_mult_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;

  logic        s16 = 1'b0, s4 = 1'b0;
  logic [15:0] a16 = '0, b16 = '0;
  logic [3:0]  a4 = '0, b4 = '0;
  logic        busy16, done16, busy4, done4;
  logic [31:0] p16;
  logic [7:0]  p4;

  booth_seq_mult #(.WIDTH(16)) u_booth_seq_mult (
    .clk(clk), .rst_n(rst_n), .start(s16), .multiplicand(a16), .multiplier(b16),
    .busy(busy16), .done(done16), .product(p16));

  booth_seq_mult #(.WIDTH(4)) u_booth_seq_mult_n4 (
    .clk(clk), .rst_n(rst_n), .start(s4), .multiplicand(a4), .multiplier(b4),
    .busy(busy4), .done(done4), .product(p4));

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ref16(input logic [15:0] x, input logic [15:0] y);
    logic signed [31:0] sx, sy;
    sx = {{16{x[15]}}, x};
    sy = {{16{y[15]}}, y};
    return sx * sy;
  endfunction

  function automatic logic [7:0] ref4(input logic [3:0] x, input logic [3:0] y);
    logic signed [7:0] sx, sy;
    sx = {{4{x[3]}}, x};
    sy = {{4{y[3]}}, y};
    return 8'(sx * sy);
  endfunction

  task automatic run16(input logic [15:0] x, input logic [15:0] y, input bit ign,
                       input string tag);
    int lat;
    logic [31:0] held;
    @(negedge clk); a16 = x; b16 = y; s16 = 1'b1;
    @(negedge clk); s16 = 1'b0;
    check(busy16 == 1'b1, "R2 busy after start", 32'(busy16), 32'd1);
    lat = 0;
    while (!done16 && lat < 100) begin
      @(negedge clk); lat++;
      if (ign && lat == 3) begin a16 = ~x; b16 = y ^ 16'h5a5a; s16 = 1'b1; end
      else s16 = 1'b0;
    end
    check(lat == 16, "R3 R8 latency", 32'(lat), 32'd16);
    check(!busy16, "R3 busy low with done", 32'(busy16), 32'd0);
    check(p16 == ref16(x, y), tag, p16, ref16(x, y));
    held = p16;
    @(negedge clk);
    check(!done16, "R3 done one cycle", 32'(done16), 32'd0);
    check(p16 == held, "R6 product held", p16, held);
  endtask

  task automatic run4(input logic [3:0] x, input logic [3:0] y);
    int lat;
    @(negedge clk); a4 = x; b4 = y; s4 = 1'b1;
    @(negedge clk); s4 = 1'b0;
    lat = 0;
    while (!done4 && lat < 50) begin @(negedge clk); lat++; end
    check(lat == 4, "R3 R8 latency n4", 32'(lat), 32'd4);
    check(p4 == ref4(x, y), "R4 R7 exhaustive n4", 32'(p4), 32'(ref4(x, y)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(!busy16 && !done16, "R1 reset flags", {busy16, done16}, 32'd0);
    check(p16 == 32'd0, "R1 reset product", p16, 32'd0);
    check(p4 == 8'd0, "R1 reset product n4", 32'(p4), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy16, "R1 idle after reset", 32'(busy16), 32'd0);

    run16(16'd13, 16'd11, 1'b0, "R4 13x11");
    run16(16'hfff3, 16'd11, 1'b0, "R4 neg x pos");
    run16(16'd13, 16'hfff5, 1'b0, "R4 pos x neg");
    run16(16'h8000, 16'h8000, 1'b0, "R4 min x min");
    run16(16'h7fff, 16'h8000, 1'b0, "R4 max x min");
    run16(16'h1234, 16'haaaa, 1'b0, "R7 alternating pairs");
    run16(16'hffff, 16'h5555, 1'b0, "R7 alternating pairs");
    run16(16'h4321, 16'h0ff0, 1'b0, "R7 runs of ones");
    run16(16'h0000, 16'h8001, 1'b0, "R4 zero multiplicand");
    run16(16'h2345, 16'h0777, 1'b1, "R5 start while busy ignored");

    held = p16;
    a16 = 16'hbeef; b16 = 16'h1357;
    repeat (5) @(negedge clk);
    check(p16 == held, "R6 inputs change while idle", p16, held);

    for (int i = 0; i < 300; i++)
      run16(16'($urandom), 16'($urandom), (i % 17) == 0, "R4 random n16");

    for (int x = 0; x < 16; x++)
      for (int y = 0; y < 16; y++)
        run4(4'(x), 4'(y));

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule